// File: doc/BRIEF.md
# Video Control Line Conditioner

This block sits in front of a serial link transmitter. Each clock it takes a 24-bit pixel word and three slow control lines: data enable, horizontal sync and vertical sync. It hands both on, registered, to the framing logic. The capture edge can be chosen. In one mode a glitch filter sits on the control lines, and it removes any level that does not persist for a minimum number of captured samples. The pixel path is delayed by the same amount, so the two paths stay aligned.

The link carries control lines in a narrow side band, so each line has a limited number of level changes it may make over a sliding window. The block enforces that budget. A change that would exceed the budget is held back until the window frees up, and a sticky per-line flag records that this happened. A power-enable input clears everything and keeps the block idle while it is low.

Top module: `link_ctl_conditioner`

## Requirements
- R1: The 24-bit pixel word passes unchanged from `pix_in` to `pix_out`. Red sits in bits 7:0, green in bits 15:8 and blue in bits 23:16. Control bit 0 is data enable, bit 1 is horizontal sync and bit 2 is vertical sync.
- R2: With `edge_rise`=1, inputs are sampled on the rising clock edge, and with the filter off they appear at the outputs after the following rising edge. With `edge_rise`=0, inputs are sampled on the falling edge and appear after the next rising edge.
- R3: In mode 01, a control level that is present in fewer than 3 consecutive captured samples never reaches `ctl_out`.
- R4: In mode 01, a control change is committed once 3 consecutive captured samples agree. Both control and pixel outputs then trail the unfiltered timing by exactly 2 clocks and stay aligned. A committed output level holds for at least one further clock.
- R5: In mode 00, control pulses of any width, including a single sample, pass through.
- R6: Modes 10 and 11 filter like mode 00 and drive `legacy` high. `legacy` is low in modes 00 and 01.
- R7: Data enable and horizontal sync each make at most 2 output changes in any 130-clock span. A refused change is applied on the first clock at which the older of the two previous changes lies 130 clocks back.
- R8: Vertical sync makes at most 1 output change per 130 clocks. A change exactly 130 clocks after the previous one is accepted, and a refused change is applied at that point.
- R9: A refused change sets that channel's bit in `viol` (bit order as in R1). The bit stays set until power-down.
- R10: While `pwr_en` is low, `pix_out`, `ctl_out` and `viol` are zero. Falling `pwr_en` clears them without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| pwr_en | input | 1 | Active-high enable; low resets and idles the block |
| edge_rise | input | 1 | 1 = capture on rising edge, 0 = capture on falling edge |
| mode | input | 2 | 00 filter off, 01 filter on, 10/11 legacy (filter off) |
| pix_in | input | 24 | Pixel word |
| ctl_in | input | 3 | Control lines: bit0 DE, bit1 HS, bit2 VS |
| pix_out | output | 24 | Registered, delay-matched pixel word |
| ctl_out | output | 3 | Filtered, rate-limited control lines |
| viol | output | 3 | Sticky per-line budget violation flags |
| legacy | output | 1 | High in modes 10 and 11 |

## Verification
A corrupted filter history shows up quickly. Either a short pulse reaches `ctl_out` within two clocks of the glitch, or the pixel word and the control edge land one or more clocks apart. A wrong window age counter cannot be seen until a deferred change takes effect, so the bench places a refused change and watches the exact boundary: the cycle 129 clocks after the older change, and the cycle 130 clocks after it. A slot that ages too fast or too slowly moves that edge by one clock. A sticky flag that drops shows at the very next sample.

// File: rtl/link_ctl_conditioner.sv
module link_ctl_conditioner #(
  parameter int DW       = 24,
  parameter int CW       = 3,
  parameter int WIN      = 130,
  parameter int FILT_LEN = 3,
  parameter int BUD_FAST = 2,
  parameter int BUD_SLOW = 1,
  parameter int SLOW_CH  = 2
) (
  input  logic          clk,
  input  logic          pwr_en,
  input  logic          edge_rise,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] pix_in,
  input  logic [CW-1:0] ctl_in,
  output logic [DW-1:0] pix_out,
  output logic [CW-1:0] ctl_out,
  output logic [CW-1:0] viol,
  output logic          legacy
);
  localparam int HL = FILT_LEN - 1;
  localparam int AW = $clog2(WIN + 1);

  logic [DW-1:0] d_r, d_f, d_cap;
  logic [CW-1:0] c_r, c_f, c_cap, cand, stable;
  logic [DW-1:0] dh [HL];
  logic [CW-1:0] ch [HL];

  wire filt_on = (mode == 2'b01);
  assign legacy = mode[1];

  always_ff @(posedge clk or negedge pwr_en)
    if (!pwr_en) begin
      d_r <= '0;
      c_r <= '0;
    end else begin
      d_r <= pix_in;
      c_r <= ctl_in;
    end

  always_ff @(negedge clk or negedge pwr_en)
    if (!pwr_en) begin
      d_f <= '0;
      c_f <= '0;
    end else begin
      d_f <= pix_in;
      c_f <= ctl_in;
    end

  assign d_cap = edge_rise ? d_r : d_f;
  assign c_cap = edge_rise ? c_r : c_f;

  always_ff @(posedge clk or negedge pwr_en)
    if (!pwr_en) begin
      for (int i = 0; i < HL; i++) begin
        dh[i] <= '0;
        ch[i] <= '0;
      end
      pix_out <= '0;
    end else begin
      dh[0] <= d_cap;
      ch[0] <= c_cap;
      for (int i = 1; i < HL; i++) begin
        dh[i] <= dh[i-1];
        ch[i] <= ch[i-1];
      end
      pix_out <= filt_on ? dh[HL-1] : d_cap;
    end

  // a bit is stable when every stored sample matches the newest capture
  always_comb begin
    stable = '1;
    for (int i = 0; i < HL; i++) stable = stable & ~(ch[i] ^ c_cap);
    cand = filt_on ? ((c_cap & stable) | (ctl_out & ~stable)) : c_cap;
  end

  for (genvar j = 0; j < CW; j++) begin : g_ch
    localparam int BUD = (j == SLOW_CH) ? BUD_SLOW : BUD_FAST;
    localparam int LW  = $clog2(BUD + 1);

    logic [AW-1:0] age [BUD];
    logic [LW-1:0] live;
    logic          o_q, v_q;

    wire want = cand[j] ^ o_q;
    wire room = live < LW'(BUD);

    always_comb begin
      live = '0;
      for (int i = 0; i < BUD; i++)
        if (age[i] < AW'(WIN)) live = live + 1'b1;
    end

    // age[0] is the newest accepted change; ages saturate at WIN (expired)
    always_ff @(posedge clk or negedge pwr_en)
      if (!pwr_en) begin
        o_q <= 1'b0;
        v_q <= 1'b0;
        for (int i = 0; i < BUD; i++) age[i] <= AW'(WIN);
      end else begin
        for (int i = 0; i < BUD; i++)
          age[i] <= (age[i] < AW'(WIN)) ? age[i] + 1'b1 : age[i];
        if (want && room) begin
          o_q    <= cand[j];
          age[0] <= AW'(1);
          for (int i = 1; i < BUD; i++)
            age[i] <= (age[i-1] < AW'(WIN)) ? age[i-1] + 1'b1 : age[i-1];
        end
        if (want && !room) v_q <= 1'b1;
      end

    assign ctl_out[j] = o_q;
    assign viol[j]    = v_q;
  end
endmodule

// File: rtl/link_ctl_conditioner_chk.sv
module link_ctl_conditioner_chk #(
  parameter int DW      = 24,
  parameter int CW      = 3,
  parameter int WIN     = 130,
  parameter int SLOW_CH = 2
) (
  input logic          clk,
  input logic          pwr_en,
  input logic [1:0]    mode,
  input logic [DW-1:0] pix_out,
  input logic [CW-1:0] ctl_out,
  input logic [CW-1:0] viol
);
  localparam int GW = $clog2(WIN + 1);

  logic          seen;
  logic          prev;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) seen <= 1'b1;

  always_ff @(posedge clk or negedge pwr_en)
    if (!pwr_en) begin
      prev <= 1'b0;
      gap  <= GW'(WIN);
    end else begin
      prev <= ctl_out[SLOW_CH];
      if (ctl_out[SLOW_CH] != prev) gap <= GW'(1);
      else if (gap < GW'(WIN))      gap <= gap + 1'b1;
    end

  p_pd_clear_r10: assert property (@(posedge clk)
    (seen && !pwr_en) |-> (ctl_out == '0 && viol == '0 && pix_out == '0))
    else $error("p_pd_clear_r10");

  p_slow_gap_r8: assert property (@(posedge clk) disable iff (!pwr_en)
    (ctl_out[SLOW_CH] != prev) |-> (gap >= GW'(WIN)))
    else $error("p_slow_gap_r8");

  p_viol_sticky_r9: assert property (@(posedge clk) disable iff (!pwr_en)
    $past(pwr_en) |-> ((viol & $past(viol)) == $past(viol)))
    else $error("p_viol_sticky_r9");

  p_filt_hold_r4: assert property (@(posedge clk) disable iff (!pwr_en)
    (mode == 2'b01 && $past(mode) == 2'b01 && $past(ctl_out) != $past(ctl_out, 2))
      |-> (((ctl_out ^ $past(ctl_out)) & ($past(ctl_out) ^ $past(ctl_out, 2))) == '0))
    else $error("p_filt_hold_r4");
endmodule

bind link_ctl_conditioner link_ctl_conditioner_chk #(
  .DW(DW), .CW(CW), .WIN(WIN), .SLOW_CH(SLOW_CH)
) chk_i (
  .clk(clk), .pwr_en(pwr_en), .mode(mode),
  .pix_out(pix_out), .ctl_out(ctl_out), .viol(viol)
);

// File: tb/link_ctl_conditioner_tb_top.sv
module link_ctl_conditioner_tb_top;
  logic        clk = 1'b0;
  logic        pwr_en, edge_rise;
  logic [1:0]  mode;
  logic [23:0] pix_in, pix_out;
  logic [2:0]  ctl_in, ctl_out, viol;
  logic        legacy;
  int          cyc = 0;
  int          tests = 0;
  int          fails = 0;

  typedef struct {
    int          due;
    logic [23:0] pix;
    logic [2:0]  ctl;
    logic [2:0]  viol;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_ctl_conditioner dut_i (
    .clk(clk), .pwr_en(pwr_en), .edge_rise(edge_rise), .mode(mode),
    .pix_in(pix_in), .ctl_in(ctl_in), .pix_out(pix_out),
    .ctl_out(ctl_out), .viol(viol), .legacy(legacy)
  );

  // monitor: pops due items and compares at the falling edge
  always @(negedge clk) begin
    exp_t e;
    while (q.size() > 0 && q[0].due <= cyc) begin
      e = q.pop_front();
      tests++;
      if (e.due < cyc) begin
        fails++;
        $display("FAIL %s missed at cycle %0d act=none exp=due %0d", e.tag, cyc, e.due);
      end else if (pix_out !== e.pix || ctl_out !== e.ctl || viol !== e.viol) begin
        fails++;
        $display("FAIL %s cycle %0d act pix=%h ctl=%b viol=%b exp pix=%h ctl=%b viol=%b",
                 e.tag, cyc, pix_out, ctl_out, viol, e.pix, e.ctl, e.viol);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drv(input logic [23:0] p, input logic [2:0] c);
    pix_in = p;
    ctl_in = c;
  endtask

  task automatic want(input int due, input logic [23:0] p, input logic [2:0] c,
                      input logic [2:0] v, input string tag);
    exp_t e;
    e.due = due; e.pix = p; e.ctl = c; e.viol = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() > 0) tick();
  endtask

  task automatic now_chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic power_cycle(input logic er, input logic [1:0] md);
    tick();
    pwr_en = 1'b0;
    drv(24'h0, 3'b000);
    edge_rise = er;
    mode = md;
    tick();
    tick();
    pwr_en = 1'b1;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int k;
    pwr_en = 1'b0; edge_rise = 1'b1; mode = 2'b00;
    drv(24'hFFFFFF, 3'b111);
    repeat (3) tick();
    now_chk("R10 reset pix", 32'(pix_out), 32'h0);
    now_chk("R10 reset ctl", 32'(ctl_out), 32'h0);
    now_chk("R10 reset viol", 32'(viol), 32'h0);

    // R1 R2 R5: rising capture, filter off, colour fields and single-sample pulses
    power_cycle(1'b1, 2'b00);
    k = cyc;
    want(k+2, 24'h0000FF, 3'b000, 3'b000, "R1 red field");
    want(k+3, 24'h00FF00, 3'b001, 3'b000, "R1 green field, R5 DE pulse");
    want(k+4, 24'hFF0000, 3'b000, 3'b000, "R1 blue field, R2 latency");
    want(k+5, 24'hFF0000, 3'b010, 3'b000, "R5 HS single sample");
    want(k+6, 24'hFF0000, 3'b000, 3'b000, "R5 HS pulse end");
    drv(24'h0000FF, 3'b000); tick();
    drv(24'h00FF00, 3'b001); tick();
    drv(24'hFF0000, 3'b000); tick();
    drv(24'hFF0000, 3'b010); tick();
    drv(24'hFF0000, 3'b000);
    drain();

    // R2: falling capture shows one clock sooner
    power_cycle(1'b0, 2'b00);
    k = cyc;
    want(k+1, 24'hA5C3E1, 3'b000, 3'b000, "R2 falling capture");
    want(k+2, 24'h123456, 3'b100, 3'b000, "R2 falling capture VS");
    drv(24'hA5C3E1, 3'b000); tick();
    drv(24'h123456, 3'b100);
    drain();

    // R3 R4: filter on
    power_cycle(1'b1, 2'b01);
    k = cyc;
    want(k+2, 24'h0,      3'b000, 3'b000, "R3 glitch blocked early");
    want(k+3, 24'h0,      3'b000, 3'b000, "R3 glitch blocked");
    want(k+4, 24'h111111, 3'b000, 3'b000, "R3 R4 data delayed");
    want(k+5, 24'h222222, 3'b000, 3'b000, "R3 two-sample HS dropped");
    want(k+6, 24'h333333, 3'b000, 3'b000, "R4 data delayed");
    want(k+11, 24'h333333, 3'b000, 3'b000, "R4 before commit");
    want(k+12, 24'h444444, 3'b010, 3'b000, "R4 commit aligned");
    want(k+13, 24'h555555, 3'b010, 3'b000, "R4 hold");
    want(k+14, 24'h666666, 3'b010, 3'b000, "R4 hold");
    want(k+15, 24'h777777, 3'b000, 3'b000, "R4 release aligned");
    drv(24'h111111, 3'b010); tick();
    drv(24'h222222, 3'b010); tick();
    drv(24'h333333, 3'b000);
    repeat (6) tick();
    drv(24'h444444, 3'b010); tick();
    drv(24'h555555, 3'b010); tick();
    drv(24'h666666, 3'b010); tick();
    drv(24'h777777, 3'b000);
    drain();

    // R6: legacy modes
    power_cycle(1'b1, 2'b10);
    now_chk("R6 legacy in 10", 32'(legacy), 32'h1);
    k = cyc;
    want(k+2, 24'h0, 3'b001, 3'b000, "R6 mode 10 passes pulse");
    want(k+3, 24'h0, 3'b000, 3'b000, "R6 mode 10 pulse end");
    drv(24'h0, 3'b001); tick();
    drv(24'h0, 3'b000);
    drain();
    mode = 2'b11; #1 now_chk("R6 legacy in 11", 32'(legacy), 32'h1);
    mode = 2'b00; #1 now_chk("R6 legacy off in 00", 32'(legacy), 32'h0);
    mode = 2'b01; #1 now_chk("R6 legacy off in 01", 32'(legacy), 32'h0);

    // R7 R9: third DE change inside the window is deferred
    power_cycle(1'b1, 2'b00);
    k = cyc;
    want(k+2,   24'h0, 3'b001, 3'b000, "R7 DE first change");
    want(k+11,  24'h0, 3'b001, 3'b000, "R7 DE level held");
    want(k+12,  24'h0, 3'b000, 3'b000, "R7 DE second change");
    want(k+22,  24'h0, 3'b000, 3'b001, "R7 R9 third change refused");
    want(k+131, 24'h0, 3'b000, 3'b001, "R7 still refused at 129");
    want(k+132, 24'h0, 3'b001, 3'b001, "R7 R9 applied at 130, flag kept");
    drv(24'h0, 3'b001); repeat (10) tick();
    drv(24'h0, 3'b000); repeat (10) tick();
    drv(24'h0, 3'b001);
    drain();
    power_cycle(1'b1, 2'b00);
    now_chk("R9 R10 flag cleared by power-down", 32'(viol), 32'h0);

    // R8 R9: VS budget of one, HS unaffected
    k = cyc;
    want(k+2,   24'h0, 3'b100, 3'b000, "R8 VS change");
    want(k+51,  24'h0, 3'b100, 3'b000, "R8 before second");
    want(k+52,  24'h0, 3'b110, 3'b100, "R8 R9 VS refused, HS passes");
    want(k+131, 24'h0, 3'b110, 3'b100, "R8 VS still held");
    want(k+132, 24'h0, 3'b010, 3'b100, "R8 VS applied at 130");
    drv(24'h0, 3'b100); repeat (50) tick();
    drv(24'h0, 3'b010);
    drain();

    // R8: exactly 130 apart is allowed
    power_cycle(1'b1, 2'b00);
    k = cyc;
    want(k+2,   24'h0, 3'b100, 3'b000, "R8 first VS");
    want(k+131, 24'h0, 3'b100, 3'b000, "R8 VS level");
    want(k+132, 24'h0, 3'b000, 3'b000, "R8 spacing 130 accepted");
    drv(24'h0, 3'b100); repeat (130) tick();
    drv(24'h0, 3'b000);
    drain();

    // R10: asynchronous clear while active
    power_cycle(1'b1, 2'b00);
    drv(24'hFFFFFF, 3'b111);
    repeat (4) tick();
    now_chk("R1 all lines high", {8'h0, pix_out}, {8'h0, 24'hFFFFFF});
    now_chk("R1 ctl all high", 32'(ctl_out), 32'h7);
    pwr_en = 1'b0;
    #2;
    now_chk("R10 async clear pix", 32'(pix_out), 32'h0);
    now_chk("R10 async clear ctl", 32'(ctl_out), 32'h0);
    repeat (2) tick();
    now_chk("R10 held idle", {5'h0, ctl_out, viol, pix_out}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule